// File: doc/BRIEF.md
# FIFO-Buffered Asynchronous Serial Port

This block is an asynchronous serial port that sits on a simple 16-bit register bus. Software queues bytes into a 16-entry transmit FIFO. The block sends them on a single output line as frames of one start bit, eight data bits (least significant first) and one stop bit. Incoming frames on the receive line are sampled at the middle of each bit and stored in a 16-entry receive FIFO, where software reads them back one at a time.

The bit time is set by an 8-bit divider value N: every bit lasts 32*(N+1) system clocks. For a clock `clk` and a bit rate `bps`, software rounds to the nearest value with N = (clk + 16*bps)/(32*bps) - 1.

A status register reports FIFO and line conditions, and a separate line-status register holds the receive-overrun flag. A flag is cleared by reading it as 1 and then writing 0 to it. Each FIFO can be emptied through its own bit in a FIFO control register, and that bit holds the FIFO empty until software writes the bit back to 0.

Register offsets, with `regAddr` carrying the byte offset:

| Offset | Register |
|---|---|
| 0x00 | mode |
| 0x04 | baud divider |
| 0x08 | control |
| 0x0C | transmit data |
| 0x10 | status |
| 0x14 | receive data |
| 0x18 | FIFO control |
| 0x1C | receive count |
| 0x24 | line status |

Top module: `fifo_serial_port`

## Requirements
- R1: After reset:
  - the status register (0x10) reads 0x0040, that is, only bit 6 (transmit end) is set;
  - the receive count (0x1C) reads 0;
  - the line status (0x24) reads 0;
  - `txLine` is high.
- R2: A transmitted frame is:
  - a low start bit, then the eight data bits least significant first, then a high stop bit;
  - each bit lasts exactly 32*(N+1) clocks, where N is the baud register (0x04, bits 7:0);
  - a frame starts on the clock edge after the one at which the byte is in the FIFO with the transmitter idle and enabled;
  - back-to-back frames are separated by one high clock.
- R3: While control bit 5 (0x08) is 0, no new frame starts, queued bytes wait, and `txLine` stays high.
- R4: The transmit FIFO holds 16 bytes. A write to transmit data (0x0C) while 16 bytes are waiting is dropped.
- R5: Reception, while control bit 4 is 1:
  - the receiver samples each bit at its middle and stores the byte;
  - the receive count reads in 0x1C bits 4:0;
  - a read of 0x14 returns the oldest byte in bits 7:0 and removes it;
  - status bit 0 (data ready) is set while the receive FIFO is not empty.
- R6: A read of 0x14 with the receive FIFO empty returns the byte most recently removed.
- R7: A received stop bit of 0 sets status bit 3 (framing) and bit 7 (error summary). The byte is still stored.
- R8: A frame with all-zero data and a zero stop bit also sets status bit 4 (break).
- R9: A byte that completes while the receive FIFO holds 16 bytes is discarded. It sets line-status bit 0 (overrun) and status bit 7.
- R10: Clearing a flag:
  - a write to status clears a flag only where the written bit is 0, the flag read as 1 at the latest status read, and hardware has not set the flag again since;
  - written 1s leave flags unchanged, so writing 0x0063 clears bits 3, 4 and 7 only;
  - every write uses up the preceding read;
  - line-status bit 0 clears by the same rule through 0x24.
- R11: Flags that follow a condition are re-set on every clock while the condition holds, so a clear cannot remove them:
  - bit 0 while the receive FIFO is not empty;
  - bit 1 while it holds 8 or more bytes;
  - bit 6 while the transmit FIFO is empty and the transmitter is idle.
- R12: In FIFO control (0x18):
  - bit 1 empties the receive FIFO;
  - bit 2 empties the transmit FIFO;
  - each FIFO is held empty until its bit is written back to 0.
- R13: While control bit 4 is 0, frames on `rxLine` are ignored.
- R14: The following registers read back as written:
  - mode (0x00, 16 bits);
  - baud (8 bits);
  - control (16 bits);
  - FIFO control (16 bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 6 | Register byte offset |
| regWrEn | input | 1 | Register write strobe, one clock per access |
| regRdEn | input | 1 | Register read strobe; side effects at the clock edge |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for `regAddr`, valid in the same cycle |
| rxLine | input | 1 | Serial receive line, idle high |
| txLine | output | 1 | Serial transmit line, idle high |

## Verification
The assertions check several properties on every cycle:
- the transmit FIFO count never moves on a dropped write;
- a status flag falls only after a status write;
- transmit end is present whenever the transmitter is empty and idle;
- an overrun is always latched in the line-status register;
- every frame opens with a low start bit.

Only the bench scenarios can show the rest: exact bit timing against the divider, byte order through both FIFOs, the read-then-write clearing rule with a flag set again in between, break and framing classification, and the dropped seventeenth byte on each side.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  localparam int DATA_W = 8;
  localparam int BAUD_W = 8;
  localparam int REG_W = 16;
  localparam int REG_AW = 6;
  localparam int FIFO_DEPTH = 16;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam int FRAME_W = DATA_W + 2;
  localparam int BITCLK_W = BAUD_W + 5;

  localparam logic [REG_AW-1:0] OFS_MODE   = 6'h00;
  localparam logic [REG_AW-1:0] OFS_BAUD   = 6'h04;
  localparam logic [REG_AW-1:0] OFS_CTRL   = 6'h08;
  localparam logic [REG_AW-1:0] OFS_TXDATA = 6'h0C;
  localparam logic [REG_AW-1:0] OFS_STATUS = 6'h10;
  localparam logic [REG_AW-1:0] OFS_RXDATA = 6'h14;
  localparam logic [REG_AW-1:0] OFS_FIFOC  = 6'h18;
  localparam logic [REG_AW-1:0] OFS_COUNT  = 6'h1C;
  localparam logic [REG_AW-1:0] OFS_LINE   = 6'h24;

  localparam int STS_READY = 0;
  localparam int STS_FULL  = 1;
  localparam int STS_FRAME = 3;
  localparam int STS_BREAK = 4;
  localparam int STS_TEND  = 6;
  localparam int STS_ERR   = 7;
  localparam logic [7:0] STS_MASK = 8'hDB;

  localparam int CTL_RXEN = 4;
  localparam int CTL_TXEN = 5;
  localparam int FC_RXCLR = 1;
  localparam int FC_TXCLR = 2;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rxState_e;

  typedef struct packed {
    logic              txPush;
    logic [DATA_W-1:0] txByte;
    logic              rxPop;
    logic              txFlush;
    logic              rxFlush;
    logic              txEn;
    logic              rxEn;
    logic [BAUD_W-1:0] baudDiv;
  } ctlStrobes_t;

  typedef struct packed {
    logic [CNT_W-1:0]  rxCount;
    logic [DATA_W-1:0] rxHead;
    logic              txEmpty;
    logic              txBusy;
    logic              frameErr;
    logic              breakSeen;
    logic              overrun;
  } dpStatus_t;
endpackage

// File: rtl/fsp_fifo.sv
module fsp_fifo #(
  parameter int W = 8,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  pushData,
  input  logic          pop,
  output logic [W-1:0]  headData,
  output logic [CW-1:0] count
);
  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign doPush = push && (count != CW'(DEPTH)) && !flush;
  assign doPop  = pop && (count != '0) && !flush;
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    (push && count == CW'(DEPTH) && !pop && !flush) |=> count == $past(count));
endmodule

// File: rtl/fsp_datapath.sv
module fsp_datapath import fsp_pkg::*; (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t ctl,
  input  logic        rxLine,
  output logic        txLine,
  output dpStatus_t   dpSts
);
  logic [BITCLK_W-1:0] bitLast, halfLast;
  assign bitLast  = {ctl.baudDiv, 5'b11111};
  assign halfLast = {1'b0, ctl.baudDiv, 4'b1111};

  // transmit side
  logic [DATA_W-1:0] txHead;
  logic [CNT_W-1:0] txCount;
  logic txBusy, txStart;
  logic [FRAME_W-1:0] txShift;
  logic [3:0] txBitIdx;
  logic [BITCLK_W-1:0] txClk;

  assign txStart = !txBusy && ctl.txEn && (txCount != '0);

  fsp_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) txFifo_i (
    .clk(clk), .rstN(rstN), .flush(ctl.txFlush), .push(ctl.txPush),
    .pushData(ctl.txByte), .pop(txStart), .headData(txHead), .count(txCount));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBusy <= 1'b0;
      txShift <= '1;
      txBitIdx <= '0;
      txClk <= '0;
    end else if (txStart) begin
      txShift <= {1'b1, txHead, 1'b0};
      txBusy <= 1'b1;
      txBitIdx <= '0;
      txClk <= '0;
    end else if (txBusy) begin
      if (txClk == bitLast) begin
        txClk <= '0;
        if (txBitIdx == 4'(FRAME_W - 1)) begin
          txBusy <= 1'b0;
        end else begin
          txShift <= {1'b1, txShift[FRAME_W-1:1]};
          txBitIdx <= txBitIdx + 1'b1;
        end
      end else begin
        txClk <= txClk + 1'b1;
      end
    end
  end

  assign txLine = txBusy ? txShift[0] : 1'b1;

  // receive side
  logic rxMeta, rxSync, rxPrev;
  rxState_e rxState;
  logic [BITCLK_W-1:0] rxClk;
  logic [2:0] rxBitIdx;
  logic [DATA_W-1:0] rxShift;
  logic rxDone, rxStopBad;
  logic [DATA_W-1:0] rxHead;
  logic [CNT_W-1:0] rxCount;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
      rxPrev <= 1'b1;
      rxState <= RX_IDLE;
      rxClk <= '0;
      rxBitIdx <= '0;
      rxShift <= '0;
      rxDone <= 1'b0;
      rxStopBad <= 1'b0;
    end else begin
      rxMeta <= rxLine;
      rxSync <= rxMeta;
      rxPrev <= rxSync;
      rxDone <= 1'b0;
      if (!ctl.rxEn) begin
        rxState <= RX_IDLE;
      end else begin
        case (rxState)
          RX_IDLE: begin
            if (rxPrev && !rxSync) begin
              rxState <= RX_START;
              rxClk <= '0;
            end
          end
          RX_START: begin
            if (rxClk == halfLast) begin
              rxClk <= '0;
              rxBitIdx <= '0;
              rxState <= rxSync ? RX_IDLE : RX_DATA;
            end else begin
              rxClk <= rxClk + 1'b1;
            end
          end
          RX_DATA: begin
            if (rxClk == bitLast) begin
              rxClk <= '0;
              rxShift <= {rxSync, rxShift[DATA_W-1:1]};
              if (rxBitIdx == 3'(DATA_W - 1)) rxState <= RX_STOP;
              else rxBitIdx <= rxBitIdx + 1'b1;
            end else begin
              rxClk <= rxClk + 1'b1;
            end
          end
          default: begin
            if (rxClk == bitLast) begin
              rxState <= RX_IDLE;
              rxDone <= 1'b1;
              rxStopBad <= !rxSync;
            end else begin
              rxClk <= rxClk + 1'b1;
            end
          end
        endcase
      end
    end
  end

  fsp_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) rxFifo_i (
    .clk(clk), .rstN(rstN), .flush(ctl.rxFlush), .push(rxDone),
    .pushData(rxShift), .pop(ctl.rxPop), .headData(rxHead), .count(rxCount));

  always_comb begin
    dpSts.rxCount   = rxCount;
    dpSts.rxHead    = rxHead;
    dpSts.txEmpty   = (txCount == '0);
    dpSts.txBusy    = txBusy;
    dpSts.frameErr  = rxDone && rxStopBad;
    dpSts.breakSeen = rxDone && rxStopBad && (rxShift == '0);
    dpSts.overrun   = rxDone && (rxCount == CNT_W'(FIFO_DEPTH));
  end

  assert_start_bit_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txBusy) |-> !txLine);

  assert_rx_drop_when_full_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && rxCount == CNT_W'(FIFO_DEPTH) && !ctl.rxPop && !ctl.rxFlush)
      |=> rxCount == CNT_W'(FIFO_DEPTH));
endmodule

// File: rtl/fsp_control.sv
module fsp_control import fsp_pkg::*; #(
  parameter int RX_FULL_LEVEL = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  dpStatus_t         dpSts,
  output ctlStrobes_t       ctl
);
  logic [REG_W-1:0] modeReg, ctrlReg, fifoCtrlReg;
  logic [BAUD_W-1:0] baudReg;
  logic [7:0] stsFlags, stsArm, setEvt, clrMask;
  logic lineOvr, lineArm;
  logic [DATA_W-1:0] rxLast;
  logic stsRd, stsWr, lineRd, lineWr, rxRd;

  assign stsRd  = regRdEn && regAddr == OFS_STATUS;
  assign stsWr  = regWrEn && regAddr == OFS_STATUS;
  assign lineRd = regRdEn && regAddr == OFS_LINE;
  assign lineWr = regWrEn && regAddr == OFS_LINE;
  assign rxRd   = regRdEn && regAddr == OFS_RXDATA;

  always_comb begin
    setEvt = '0;
    setEvt[STS_READY] = dpSts.rxCount != '0;
    setEvt[STS_FULL]  = dpSts.rxCount >= CNT_W'(RX_FULL_LEVEL);
    setEvt[STS_FRAME] = dpSts.frameErr;
    setEvt[STS_BREAK] = dpSts.breakSeen;
    setEvt[STS_TEND]  = dpSts.txEmpty && !dpSts.txBusy;
    setEvt[STS_ERR]   = dpSts.frameErr || dpSts.overrun;
    clrMask = stsWr ? (stsArm & ~regWrData[7:0] & STS_MASK) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= '0;
      ctrlReg <= '0;
      fifoCtrlReg <= '0;
      baudReg <= '0;
      stsFlags <= 8'h40;
      stsArm <= '0;
      lineOvr <= 1'b0;
      lineArm <= 1'b0;
      rxLast <= '0;
    end else begin
      if (regWrEn) begin
        case (regAddr)
          OFS_MODE:  modeReg <= regWrData;
          OFS_BAUD:  baudReg <= regWrData[BAUD_W-1:0];
          OFS_CTRL:  ctrlReg <= regWrData;
          OFS_FIFOC: fifoCtrlReg <= regWrData;
          default: ;
        endcase
      end
      stsFlags <= (stsFlags & ~clrMask) | setEvt;
      if (stsRd)      stsArm <= stsFlags & STS_MASK & ~setEvt;
      else if (stsWr) stsArm <= '0;
      else            stsArm <= stsArm & ~setEvt;
      lineOvr <= (lineOvr && !(lineWr && lineArm && !regWrData[0])) || dpSts.overrun;
      if (lineRd)      lineArm <= lineOvr && !dpSts.overrun;
      else if (lineWr) lineArm <= 1'b0;
      else             lineArm <= lineArm && !dpSts.overrun;
      if (rxRd && dpSts.rxCount != '0) rxLast <= dpSts.rxHead;
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      OFS_MODE:   regRdData = modeReg;
      OFS_BAUD:   regRdData = REG_W'(baudReg);
      OFS_CTRL:   regRdData = ctrlReg;
      OFS_STATUS: regRdData = REG_W'(stsFlags);
      OFS_RXDATA: regRdData = REG_W'((dpSts.rxCount != '0) ? dpSts.rxHead : rxLast);
      OFS_FIFOC:  regRdData = fifoCtrlReg;
      OFS_COUNT:  regRdData = REG_W'(dpSts.rxCount);
      OFS_LINE:   regRdData = REG_W'(lineOvr);
      default:    regRdData = '0;
    endcase
  end

  always_comb begin
    ctl.txPush  = regWrEn && regAddr == OFS_TXDATA;
    ctl.txByte  = regWrData[DATA_W-1:0];
    ctl.rxPop   = rxRd;
    ctl.txFlush = fifoCtrlReg[FC_TXCLR];
    ctl.rxFlush = fifoCtrlReg[FC_RXCLR];
    ctl.txEn    = ctrlReg[CTL_TXEN];
    ctl.rxEn    = ctrlReg[CTL_RXEN];
    ctl.baudDiv = baudReg;
  end

  assert_flag_falls_on_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(stsFlags) & ~stsFlags)) |-> $past(stsWr));

  assert_line_falls_on_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lineOvr) |-> $past(lineWr));

  assert_tend_held_R11: assert property (@(posedge clk) disable iff (!rstN)
    (dpSts.txEmpty && !dpSts.txBusy) |=> stsFlags[STS_TEND]);

  assert_overrun_latched_R9: assert property (@(posedge clk) disable iff (!rstN)
    dpSts.overrun |=> (lineOvr && stsFlags[STS_ERR]));
endmodule

// File: rtl/fifo_serial_port.sv
module fifo_serial_port import fsp_pkg::*; #(
  parameter int RX_FULL_LEVEL = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              rxLine,
  output logic              txLine
);
  ctlStrobes_t ctl;
  dpStatus_t dpSts;

  fsp_control #(.RX_FULL_LEVEL(RX_FULL_LEVEL)) control_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regWrData(regWrData), .regRdData(regRdData),
    .dpSts(dpSts), .ctl(ctl));

  fsp_datapath datapath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rxLine(rxLine),
    .txLine(txLine), .dpSts(dpSts));
endmodule

// File: tb/fifo_serial_port_tb.sv
module fifo_serial_port_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [5:0] regAddr = '0;
  logic regWrEn = 1'b0;
  logic regRdEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic rxLine = 1'b1;
  logic txLine;

  int nChecks = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  fifo_serial_port dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regWrData(regWrData), .regRdData(regRdData),
    .rxLine(rxLine), .txLine(txLine));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model of the transmit line, stepped every clock
  logic [7:0] txQ[$];
  int mBusy = 0, mCnt = 0, mIdx = 0;
  logic [9:0] mFrame = '1;
  logic mTxEn = 1'b0;
  logic [15:0] mFifoCtl = '0;
  int mBaud = 0;
  logic expTx = 1'b1;

  always @(posedge clk) begin
    if (!rstN) begin
      txQ.delete();
      mBusy = 0; mCnt = 0; mIdx = 0; mTxEn = 1'b0; mFifoCtl = '0; mBaud = 0;
    end else begin
      if (mBusy == 0 && mTxEn && txQ.size() > 0) begin
        mFrame = {1'b1, txQ.pop_front(), 1'b0};
        mBusy = 1; mIdx = 0; mCnt = 0;
      end else if (mBusy != 0) begin
        if (mCnt == 32 * (mBaud + 1) - 1) begin
          mCnt = 0;
          if (mIdx == 9) mBusy = 0;
          else mIdx++;
        end else mCnt++;
      end
      if (regWrEn) begin
        case (regAddr)
          6'h0C: if (!mFifoCtl[2] && txQ.size() < 16) txQ.push_back(regWrData[7:0]);
          6'h08: mTxEn = regWrData[5];
          6'h18: mFifoCtl = regWrData;
          6'h04: mBaud = int'(regWrData[7:0]);
          default: ;
        endcase
      end
      if (mFifoCtl[2]) txQ.delete();
    end
    expTx = (mBusy != 0) ? mFrame[mIdx] : 1'b1;
  end

  // R2 R3 R4 R12: transmit line compared with the model on every clock
  always @(negedge clk) begin
    if (rstN) check("R2 txLine per-clock", {15'b0, txLine}, {15'b0, expTx});
  end

  task automatic busWrite(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic expectReg(input string req, input logic [5:0] a, input logic [15:0] exp);
    logic [15:0] v;
    busRead(a, v);
    check(req, v, exp);
  endtask

  task automatic sendRx(input logic [7:0] b, input logic stopVal, input int bitClk);
    @(negedge clk);
    rxLine = 1'b0;
    repeat (bitClk) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxLine = b[i];
      repeat (bitClk) @(negedge clk);
    end
    rxLine = stopVal;
    repeat (bitClk) @(negedge clk);
    rxLine = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic finishRun;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [15:0] v;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    expectReg("R1 status", 6'h10, 16'h0040);
    expectReg("R1 rx count", 6'h1C, 16'h0000);
    expectReg("R1 line status", 6'h24, 16'h0000);
    check("R1 txLine idle", {15'b0, txLine}, 16'h0001);

    // R14 readback
    busWrite(6'h00, 16'hA55A);
    expectReg("R14 mode", 6'h00, 16'hA55A);
    busWrite(6'h04, 16'h0002);
    expectReg("R14 baud", 6'h04, 16'h0002);
    busWrite(6'h18, 16'h0000);
    expectReg("R14 fifo control", 6'h18, 16'h0000);
    busWrite(6'h08, 16'h0030);
    expectReg("R14 control", 6'h08, 16'h0030);

    // R2 frames at N=2, R10/R11 transmit end
    busWrite(6'h0C, 16'h005A);
    busWrite(6'h0C, 16'h00C3);
    repeat (5) @(negedge clk);
    expectReg("R10 status before clear", 6'h10, 16'h0040);
    busWrite(6'h10, 16'h00BF);
    expectReg("R10 tend cleared while busy", 6'h10, 16'h0000);
    repeat (2000) @(negedge clk);
    expectReg("R11 tend set again when idle", 6'h10, 16'h0040);
    busRead(6'h10, v);
    busWrite(6'h10, 16'h0000);
    expectReg("R11 tend not clearable while idle", 6'h10, 16'h0040);

    // R3 gating and R4 seventeenth byte dropped, N=0
    busWrite(6'h04, 16'h0000);
    busWrite(6'h08, 16'h0010);
    for (int i = 1; i <= 17; i++) busWrite(6'h0C, 16'(i));
    repeat (50) @(negedge clk);
    check("R3 txLine high while disabled", {15'b0, txLine}, 16'h0001);
    busWrite(6'h08, 16'h0030);
    repeat (16 * 321 + 100) @(negedge clk);
    check("R4 line idle after 16 frames", {15'b0, txLine}, 16'h0001);

    // R12 transmit flush
    busWrite(6'h08, 16'h0010);
    busWrite(6'h0C, 16'h00AA);
    busWrite(6'h0C, 16'h00BB);
    busWrite(6'h18, 16'h0004);
    busWrite(6'h18, 16'h0000);
    busWrite(6'h08, 16'h0030);
    repeat (400) @(negedge clk);
    check("R12 tx flush sent nothing", {15'b0, txLine}, 16'h0001);

    // R5 / R6 reception
    sendRx(8'h3C, 1'b1, 32);
    expectReg("R5 rx count", 6'h1C, 16'h0001);
    expectReg("R5 data ready", 6'h10, 16'h0041);
    expectReg("R5 rx data", 6'h14, 16'h003C);
    expectReg("R5 count after read", 6'h1C, 16'h0000);
    expectReg("R6 empty read returns last", 6'h14, 16'h003C);
    busRead(6'h10, v);
    busWrite(6'h10, 16'h00FE);
    expectReg("R10 ready cleared", 6'h10, 16'h0040);

    // R7 framing, R8 break, R10 survival
    sendRx(8'hA5, 1'b0, 32);
    expectReg("R7 framing flags", 6'h10, 16'h00C9);
    expectReg("R7 byte kept", 6'h1C, 16'h0001);
    busRead(6'h10, v);
    sendRx(8'h00, 1'b0, 32);
    busWrite(6'h10, 16'h0000);
    expectReg("R8 break and R10 survival", 6'h10, 16'h00D9);
    busRead(6'h10, v);
    busWrite(6'h10, 16'h0063);
    expectReg("R10 0x63 clears errors only", 6'h10, 16'h0041);
    sendRx(8'h11, 1'b0, 32);
    busWrite(6'h10, 16'h0000);
    expectReg("R10 no clear without read", 6'h10, 16'h00C9);
    busRead(6'h10, v);
    busWrite(6'h10, 16'h0063);

    // R12 receive flush
    busWrite(6'h18, 16'h0002);
    busWrite(6'h18, 16'h0000);
    expectReg("R12 rx flushed", 6'h1C, 16'h0000);
    busRead(6'h10, v);
    busWrite(6'h10, 16'h00FE);
    expectReg("R12 status after flush", 6'h10, 16'h0040);

    // R11 threshold
    for (int i = 0; i < 8; i++) sendRx(8'(8'h80 + i), 1'b1, 32);
    expectReg("R11 threshold flag", 6'h10, 16'h0043);
    busRead(6'h10, v);
    busWrite(6'h10, 16'h0000);
    expectReg("R11 level flags kept", 6'h10, 16'h0043);

    // R9 overrun
    for (int i = 8; i < 17; i++) sendRx(8'(8'h80 + i), 1'b1, 32);
    expectReg("R9 count full", 6'h1C, 16'h0010);
    expectReg("R9 line overrun", 6'h24, 16'h0001);
    expectReg("R9 error summary", 6'h10, 16'h00C3);
    for (int i = 0; i < 16; i++) expectReg("R5 fifo order", 6'h14, 16'(8'h80 + i));
    expectReg("R6 last after drain", 6'h14, 16'h008F);
    busRead(6'h24, v);
    busWrite(6'h24, 16'h0000);
    expectReg("R10 line status cleared", 6'h24, 16'h0000);

    // R13 receiver disabled
    busWrite(6'h08, 16'h0020);
    sendRx(8'h77, 1'b1, 32);
    expectReg("R13 frame ignored", 6'h1C, 16'h0000);

    repeat (10) @(negedge clk);
    finishRun();
  end
endmodule